// File: doc/BRIEF.md
# Sequential Restoring Mantissa Divider

This unit divides one normalized floating-point mantissa by another and returns a normalized quotient mantissa, a corrected exponent difference and a sticky flag. Each operand mantissa is an unsigned integer of `MANT_W` bits whose top bit is the explicit leading one, so its value lies in [1, 2). The lowest two bits of the mantissa format are the guard and round positions. The quotient uses the same layout. The unit is meant to sit behind the special-operand and sign logic of a floating-point divide path, and in front of its rounding and packing stage.

A single pulse on `start_i` loads the operands. In that same cycle the unit finds out whether X is below Y. If it is, the dividend is doubled and the exponent is lowered by one, so the top quotient bit is always a one. After that, one quotient bit is produced per clock, from the most significant bit down. Each bit comes from the sign of a trial subtraction of the divisor from the shifted partial remainder. The loop always runs its full length. When it ends, `done_o` pulses for one cycle and the sticky flag reports whether any remainder was left. The results stay on the outputs until the next accepted start.

Top module: `mant_div_seq`

## Requirements
- R1: `start_i` is accepted only on a clock edge where `busy_o` is low. A start raised while busy is ignored and does not change the result of the running division.
- R2: `busy_o` is high from the accepting edge up to the completing edge. `done_o` is a single-cycle pulse that rises exactly `MANT_W-1` clock edges after the accepting edge, with `busy_o` falling on the same edge. `busy_o` and `done_o` are never high together.
- R3: When X >= Y (mantissas as unsigned integers), `q_exp_o` = ex - ey and `q_mant_o` = floor(X * 2^(MANT_W-1) / Y).
- R4: When X < Y, `q_exp_o` = ex - ey - 1 and `q_mant_o` = floor(X * 2^MANT_W / Y).
- R5: When `done_o` is high, bit `MANT_W-1` of `q_mant_o` is 1.
- R6: `sticky_o` is 1 exactly when the integer division of R3 or R4 leaves a nonzero remainder.
- R7: `q_exp_o` is `EXP_W+1` bits two's complement and holds the exact difference for all signed `EXP_W`-bit exponent inputs. It covers the range from -2^EXP_W to 2^EXP_W - 1 and never wraps.
- R8: Once a division has completed, `q_mant_o`, `q_exp_o` and `sticky_o` stay unchanged until the next accepted start, whatever the operand inputs do.
- R9: After a synchronous active-low reset, `busy_o`, `done_o`, `sticky_o`, `q_mant_o` and `q_exp_o` are all zero.
- R10: The latency of R2 holds for every operand pair, including equal mantissas and exact quotients whose partial remainder reaches zero early.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Load operands and begin a division when idle |
| x_mant_i | input | MANT_W | Dividend mantissa, top bit set |
| y_mant_i | input | MANT_W | Divisor mantissa, top bit set |
| x_exp_i | input | EXP_W | Dividend exponent, signed |
| y_exp_i | input | EXP_W | Divisor exponent, signed |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| q_mant_o | output | MANT_W | Normalized quotient mantissa with guard and round bits |
| q_exp_o | output | EXP_W+1 | Result exponent, signed |
| sticky_o | output | 1 | Nonzero final remainder |

## Verification
The bench aims at the pre-normalization boundary. It uses equal mantissas, a divisor one unit above the dividend, and the largest and smallest mantissas in both orders. A design that compared in the wrong direction would return an exponent off by one and a quotient with no leading one. Exact quotients such as 1.5/1.0 check that the loop keeps going after the remainder hits zero and that sticky stays clear. A design that stopped early would shift the latency. A design that took sticky from the wrong register would report a bogus inexact result. Extreme exponent pairs would expose a difference that wraps. Starts raised in mid-division, and operand inputs that keep changing while idle, would catch a unit that reloads while busy or lets its results drift.

// File: rtl/mdiv_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the sequential mantissa divider.
// Assumes nothing beyond being compiled before the modules that import it.
package mdiv_pkg;
    typedef enum logic {
        MD_IDLE = 1'b0,
        MD_RUN  = 1'b1
    } mdiv_state_e;
endpackage

// File: rtl/mdiv_trial_sub.sv
`timescale 1ns/1ps
// Module: mdiv_trial_sub
// Subtracts the divisor from a trial operand that is up to one bit wider.
// It reports whether the difference is non-negative, using the borrow
// (the sign bit of the extended difference) and no magnitude comparator.
// Assumes: when fits_o is high, the caller only needs the low W bits of
// the difference.
module mdiv_trial_sub #(
    parameter int W = 128
) (
    input  logic [W:0]   opa_i,
    input  logic [W-1:0] opb_i,
    output logic [W-1:0] diff_o,
    output logic         fits_o
);
    localparam int XW = W + 2;

    logic [XW-1:0] wide_diff;

    // Extended subtraction whose top bit is the sign of the difference.
    always_comb begin
        wide_diff = {1'b0, opa_i} - {2'b00, opb_i};
        fits_o    = ~wide_diff[XW-1];
        diff_o    = wide_diff[W-1:0];
    end
endmodule

// File: rtl/mdiv_ctrl.sv
`timescale 1ns/1ps
// Module: mdiv_ctrl
// Sequencer for the divider: accepts a start only when idle, then counts
// ITER step cycles and raises a one-cycle done pulse on the completing edge.
// Assumes ITER >= 2.
module mdiv_ctrl #(
    parameter int ITER = 127
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic load_o,
    output logic step_o,
    output logic busy_o,
    output logic done_o
);
    import mdiv_pkg::*;

    localparam int CNT_W = $clog2(ITER + 1);

    mdiv_state_e      state_q;
    logic [CNT_W-1:0] left_q;

    // Decode the load and step strobes from the current state.
    always_comb begin
        load_o = (state_q == MD_IDLE) && start_i;
        step_o = (state_q == MD_RUN);
        busy_o = (state_q == MD_RUN);
    end

    // State, remaining-step counter and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MD_IDLE;
            left_q  <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (load_o) begin
                state_q <= MD_RUN;
                left_q  <= CNT_W'(ITER);
            end else if (step_o) begin
                left_q <= left_q - 1'b1;
                if (left_q == CNT_W'(1)) begin
                    state_q <= MD_IDLE;
                    done_o  <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mdiv_exp_unit.sv
`timescale 1ns/1ps
// Module: mdiv_exp_unit
// Forms ex - ey - dec in a result one bit wider than the inputs, so that
// no pair of signed EW-bit exponents can wrap.
// Assumes dec is 0 or 1.
module mdiv_exp_unit #(
    parameter int EW = 16
) (
    input  logic signed [EW-1:0] ex_i,
    input  logic signed [EW-1:0] ey_i,
    input  logic                 dec_i,
    output logic signed [EW:0]   res_o
);
    logic signed [EW:0] ex_w;
    logic signed [EW:0] ey_w;

    // Sign-extend both exponents and subtract, applying the decrement.
    always_comb begin
        ex_w  = {ex_i[EW-1], ex_i};
        ey_w  = {ey_i[EW-1], ey_i};
        res_o = ex_w - ey_w - $signed({{EW{1'b0}}, dec_i});
    end
endmodule

// File: rtl/mant_div_seq.sv
`timescale 1ns/1ps
// Module: mant_div_seq
// Sequential restoring divider for normalized mantissas.
// The load cycle pre-normalizes: it uses X - Y when X >= Y and 2X - Y
// otherwise, and decrements the exponent in the second case. That gives
// the first quotient bit, which is always one. Each of the next
// MANT_W-1 cycles shifts the remainder left, subtracts the divisor and
// keeps the difference when it is non-negative. Sticky is the OR of the
// final remainder.
// Assumes: both mantissas have bit MANT_W-1 set. Special operands, the sign
// and rounding are handled outside.
module mant_div_seq #(
    parameter int MANT_W = 128,
    parameter int EXP_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [MANT_W-1:0]        x_mant_i,
    input  logic [MANT_W-1:0]        y_mant_i,
    input  logic signed [EXP_W-1:0]  x_exp_i,
    input  logic signed [EXP_W-1:0]  y_exp_i,
    output logic                     busy_o,
    output logic                     done_o,
    output logic [MANT_W-1:0]        q_mant_o,
    output logic signed [EXP_W:0]    q_exp_o,
    output logic                     sticky_o
);
    localparam int ITER = MANT_W - 1;

    logic                    load;
    logic                    step;
    logic                    x_ge_y;
    logic [MANT_W-1:0]       pre_diff;
    logic [MANT_W:0]         trial_a;
    logic [MANT_W-1:0]       trial_b;
    logic [MANT_W-1:0]       trial_diff;
    logic                    trial_fits;
    logic signed [EXP_W:0]   exp_next;

    logic [MANT_W-1:0]       rem_q;
    logic [MANT_W-1:0]       y_q;
    logic [MANT_W-1:0]       quo_q;
    logic signed [EXP_W:0]   exp_q;

    mdiv_ctrl #(.ITER(ITER)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .load_o  (load),
        .step_o  (step),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    // Pre-normalization test: sign of X - Y on the incoming operands.
    mdiv_trial_sub #(.W(MANT_W)) u_pre_sub (
        .opa_i  ({1'b0, x_mant_i}),
        .opb_i  (y_mant_i),
        .diff_o (pre_diff),
        .fits_o (x_ge_y)
    );

    // Select the trial operands: the pre-normalized dividend on load,
    // the doubled remainder on each step.
    always_comb begin
        if (load) begin
            trial_a = x_ge_y ? {1'b0, x_mant_i} : {x_mant_i, 1'b0};
            trial_b = y_mant_i;
        end else begin
            trial_a = {rem_q, 1'b0};
            trial_b = y_q;
        end
    end

    // One trial subtraction per cycle decides the next quotient bit.
    mdiv_trial_sub #(.W(MANT_W)) u_step_sub (
        .opa_i  (trial_a),
        .opb_i  (trial_b),
        .diff_o (trial_diff),
        .fits_o (trial_fits)
    );

    mdiv_exp_unit #(.EW(EXP_W)) u_exp (
        .ex_i  (x_exp_i),
        .ey_i  (y_exp_i),
        .dec_i (~x_ge_y),
        .res_o (exp_next)
    );

    // Datapath registers: divisor, partial remainder, quotient shifter, exponent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            y_q   <= '0;
            quo_q <= '0;
            exp_q <= '0;
        end else if (load) begin
            y_q   <= y_mant_i;
            rem_q <= trial_diff;
            quo_q <= {{(MANT_W-1){1'b0}}, trial_fits};
            exp_q <= exp_next;
        end else if (step) begin
            rem_q <= trial_fits ? trial_diff : trial_a[MANT_W-1:0];
            quo_q <= {quo_q[MANT_W-2:0], trial_fits};
        end
    end

    // Drive the result ports from the working registers.
    always_comb begin
        q_mant_o = quo_q;
        q_exp_o  = exp_q;
        sticky_o = |rem_q;
    end
endmodule

// File: rtl/mant_div_seq_chk.sv
`timescale 1ns/1ps
// Module: mant_div_seq_chk
// Property checker bound into mant_div_seq. It watches the handshake, the
// latency, the quotient normalization, the remainder bound and the hold of
// results while idle.
// Assumes it is attached through the bind statement below.
module mant_div_seq_chk #(
    parameter int MANT_W = 128,
    parameter int EXP_W  = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start_i,
    input logic                   busy_o,
    input logic                   done_o,
    input logic [MANT_W-1:0]      q_mant_o,
    input logic signed [EXP_W:0]  q_exp_o,
    input logic [MANT_W-1:0]      rem_q,
    input logic [MANT_W-1:0]      y_q
);
    localparam int LW = $clog2(MANT_W) + 2;

    logic [LW-1:0] lat_q;

    // Count edges from the accepting edge, for the latency window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else if (start_i && !busy_o) begin
            lat_q <= LW'(1);
        end else if (busy_o) begin
            lat_q <= lat_q + 1'b1;
        end
    end

    p_start_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(q_exp_o));

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (lat_q == LW'(MANT_W)));

    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_busy_done_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    p_lead_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> q_mant_o[MANT_W-1]);

    p_rem_below_div_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (rem_q < y_q));

    p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(q_mant_o) && $stable(q_exp_o)));
endmodule

bind mant_div_seq mant_div_seq_chk #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .q_mant_o (q_mant_o),
    .q_exp_o  (q_exp_o),
    .rem_q    (rem_q),
    .y_q      (y_q)
);

// File: tb/mant_div_seq_bench.sv
`timescale 1ns/1ps
// Bench for mant_div_seq. A behavioural model (wide integer division plus
// a countdown) runs alongside and is compared on every falling edge.
module mant_div_seq_bench;
    localparam int W  = 128;
    localparam int EW = 16;
    localparam int NW = 2 * W + 1;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start_i = 1'b0;
    logic [W-1:0]         x_mant_i = '0;
    logic [W-1:0]         y_mant_i = '0;
    logic signed [EW-1:0] x_exp_i = '0;
    logic signed [EW-1:0] y_exp_i = '0;
    logic                 busy_o;
    logic                 done_o;
    logic [W-1:0]         q_mant_o;
    logic signed [EW:0]   q_exp_o;
    logic                 sticky_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit cmp_en = 1'b0;
    string note = "";

    // Reference model state.
    bit           m_busy, m_done, m_s, m_xge;
    int           m_cnt, m_e;
    logic [W-1:0] m_q;

    mant_div_seq #(.MANT_W(W), .EXP_W(EW)) u_mant_div_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .x_mant_i (x_mant_i),
        .y_mant_i (y_mant_i),
        .x_exp_i  (x_exp_i),
        .y_exp_i  (y_exp_i),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .q_mant_o (q_mant_o),
        .q_exp_o  (q_exp_o),
        .sticky_o (sticky_o)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [255:0] act,
                       input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, note, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Model: quotient and remainder by wide division, latency by countdown.
    always @(posedge clk) begin
        logic [NW-1:0] num, den, quo, rem;
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_cnt = 0; m_q = '0; m_e = 0; m_s = 0; m_xge = 1;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_busy = 0;
                    m_done = 1;
                end
            end else if (start_i) begin
                m_xge = (x_mant_i >= y_mant_i);
                num   = NW'(x_mant_i) << (m_xge ? W - 1 : W);
                den   = NW'(y_mant_i);
                quo   = num / den;
                rem   = num % den;
                m_q   = quo[W-1:0];
                m_s   = (rem != 0);
                m_e   = int'(x_exp_i) - int'(y_exp_i) - (m_xge ? 0 : 1);
                m_busy = 1;
                m_cnt  = W - 1;
            end
        end
    end

    // Compare the design with the model on every falling edge.
    always @(negedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            finish_run();
        end
        if (cmp_en) begin
            chk(busy_o == m_busy, "R2 busy_o (R1 starts while busy ignored)", busy_o, m_busy);
            chk(done_o == m_done, "R2 done_o latency (R10 full length)", done_o, m_done);
            if (!m_busy) begin
                chk(q_mant_o == m_q, m_done ? (m_xge ? "R3 quotient" : "R4 quotient") : "R8 held quotient",
                    q_mant_o, m_q);
                chk(int'(q_exp_o) == m_e, m_done ? (m_xge ? "R3 exponent R7" : "R4 exponent R7")
                    : "R8 held exponent", q_exp_o, m_e);
                chk(sticky_o == m_s, m_done ? "R6 sticky" : "R8 held sticky", sticky_o, m_s);
                if (m_done)
                    chk(q_mant_o[W-1] == 1'b1, "R5 leading one", q_mant_o[W-1], 1);
            end
        end
    end

    function automatic logic [W-1:0] rnd_mant();
        logic [W-1:0] v = '0;
        for (int i = 0; i < W; i += 32) v = (v << 32) | W'($urandom);
        v[W-1] = 1'b1;
        return v;
    endfunction

    // Run one division; optionally raise a stray start after poke cycles.
    task automatic run_op(input logic [W-1:0] x, input logic [W-1:0] y,
                          input logic signed [EW-1:0] ex, input logic signed [EW-1:0] ey,
                          input int poke, input string n);
        note = n;
        @(negedge clk);
        start_i = 1; x_mant_i = x; y_mant_i = y; x_exp_i = ex; y_exp_i = ey;
        @(negedge clk);
        start_i = 0; x_mant_i = rnd_mant(); y_mant_i = rnd_mant();
        if (poke > 0) begin
            repeat (poke) @(negedge clk);
            start_i = 1; x_mant_i = rnd_mant(); y_mant_i = rnd_mant();
            x_exp_i = EW'($urandom); y_exp_i = EW'($urandom);
            @(negedge clk);
            start_i = 0;
        end
        while (!m_done) @(negedge clk);
        // Idle cycles with moving operands: results must hold (R8).
        repeat (3) begin
            @(negedge clk);
            x_mant_i = rnd_mant(); y_mant_i = rnd_mant(); x_exp_i = EW'($urandom);
        end
    endtask

    localparam logic [W-1:0] ONE   = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] ALL1  = '1;
    localparam logic [W-1:0] ONE5  = {2'b11, {(W-2){1'b0}}};
    localparam logic [W-1:0] ONE25 = {3'b101, {(W-3){1'b0}}};

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        note = "after reset";
        chk(busy_o == 0, "R9 busy_o reset", busy_o, 0);
        chk(done_o == 0, "R9 done_o reset", done_o, 0);
        chk(q_mant_o == '0, "R9 q_mant_o reset", q_mant_o, 0);
        chk(q_exp_o == '0, "R9 q_exp_o reset", q_exp_o, 0);
        chk(sticky_o == 0, "R9 sticky_o reset", sticky_o, 0);
        cmp_en = 1;
        run_op(ONE5, ONE5, 16'sd3, 16'sd3, 0, "R10 equal mantissas");
        run_op(ONE5, ONE, 16'sd10, -16'sd4, 0, "R10 exact 1.5/1.0");
        run_op(ONE, ONE5, -16'sd2, 16'sd5, 0, "R4 1.0/1.5");
        run_op(ONE5, ONE25, 16'sd0, 16'sd0, 0, "R3 1.5/1.25");
        run_op(ALL1, ONE, 16'sd1, 16'sd1, 0, "R3 max/min");
        run_op(ONE, ALL1, 16'sd1, 16'sd1, 0, "R4 min/max");
        run_op(ONE25, ONE25 + 1'b1, 16'sd7, 16'sd7, 0, "R4 divisor one ulp above");
        run_op(ONE5, ONE25, 16'sh7FFF, 16'sh8000, 0, "R7 largest exponent");
        run_op(ONE25, ONE5, 16'sh8000, 16'sh7FFF, 0, "R7 smallest exponent");
        run_op(rnd_mant(), rnd_mant(), 16'sd9, -16'sd9, 5, "R1 start while busy");
        run_op(rnd_mant(), rnd_mant(), -16'sd1, 16'sd1, W - 3, "R1 start just before done");
        for (int k = 0; k < 24; k++)
            run_op(rnd_mant(), rnd_mant(), EW'($urandom), EW'($urandom),
                   (k % 4 == 0) ? 1 + k : 0, "random");
        finish_run();
    end
endmodule